// File: doc/BRIEF.md
# Programmable START/STOP Condition Detector

This block watches the clock line (SCL) and data line (SDA) of a two-wire serial bus and reports START and STOP conditions. Both lines pass through two-flop synchronizers. A condition counts only when SCL stays high around the SDA transition for long enough. That length is measured in system clock cycles against a threshold that software programs. Because the threshold is a cycle count, software has to scale it to the system clock frequency. An accepted START sets a bus-busy flag. An accepted STOP clears it, and so does disabling the interface.

The same control byte selects a pin-edge interrupt. The source is either SCL or SDA, and the edge is either falling or rising. The request flag stays set until software clears it. A change to the pin select, the polarity select or the interface enable can itself raise the request, because the block watches the combined enable, pin and polarity level. Bit 7 of the control byte picks the setup/hold timing for a neighbouring condition generator. The detector passes that bit straight through and does not use it.

The detector state machine has four states:
- `ST_IDLE`: SCL is low, or detection is not running.
- `ST_SCL_HI`: counts the SCL-high cycles before an SDA transition.
- `ST_HOLD_STA`: counts the SCL-high cycles after SDA falls.
- `ST_HOLD_STO`: counts the SCL-high cycles after SDA rises.

The transitions are:
- From `ST_IDLE` to `ST_SCL_HI` when SCL is seen high.
- From `ST_SCL_HI` to `ST_HOLD_STA` or `ST_HOLD_STO` on a qualified SDA fall or rise.
- From `ST_SCL_HI` back to `ST_SCL_HI`, with the count restarted, on an unqualified SDA edge.
- From either hold state to `ST_SCL_HI` when the hold is complete, with a pulse.
- From either hold state to `ST_SCL_HI` when SDA changes back during the hold, with no pulse.
- From any state to `ST_IDLE` when SCL falls, or when detection stops running.

Top module: `cond_detect`

## Requirements
- R1: While reset is held, the outputs `start_pulse`, `stop_pulse`, `bus_busy` and `irq_req` are all 0.
- R2: The control byte holds a threshold T in bits 4..0, and let H = T/2. A START is accepted when all of the following hold:
  - SDA falls while SCL is high.
  - SCL was high on at least H clock edges before the first edge that samples the new SDA level.
  - SCL stays high on at least H edges after that edge.
  
  `start_pulse` is then high for exactly one cycle, starting at the edge H+2 edges after the first edge that samples the new SDA.
- R3: A STOP is accepted when SDA rises under the same SCL-high setup and hold rule as R2. `stop_pulse` is high for one cycle, with the same timing as in R2.
- R4: No pulse is produced when the setup is shorter than H, or when SCL falls before H hold edges have passed.
- R5: A threshold T of zero or any odd value drives `cfg_bad` high, combinationally. While `cfg_bad` is high, no condition is accepted.
- R6: `bus_busy` goes to 1 together with `start_pulse`. It goes to 0 together with `stop_pulse`. It also goes to 0 on the first clock edge at which `bus_en` is 0.
- R7: Bit 6 of the control byte picks the interrupt pin: 0 selects SCL and 1 selects SDA. Bit 5 picks the edge: 0 selects falling and 1 selects rising.
  - The selected edge on the selected pin sets `irq_req` at the second clock edge after the first edge that samples the new pin level.
  - The other edge does not set it.
- R8: Once set, `irq_req` stays 1 until a clock edge at which `irq_clr` is 1. A new request in that same cycle wins over the clear.
- R9: `irq_req` also sets at the next clock edge when a change of bit 5, bit 6 or `bus_en` takes the level "enabled and selected pin at its active level" from 0 to 1. The active level is high for rising and low for falling.
- R10: Bit 7 of the control byte has no effect on detection. It appears unchanged on `gen_timing_sel`.
- R11: While `bus_en` is 0, no condition is accepted and no interrupt request is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Interface enable |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| ctrl | input | 8 | Control byte: bits 4..0 threshold, bit 5 edge, bit 6 pin, bit 7 generation timing |
| irq_clr | input | 1 | Software clear of the interrupt request |
| start_pulse | output | 1 | One-cycle pulse on an accepted START |
| stop_pulse | output | 1 | One-cycle pulse on an accepted STOP |
| bus_busy | output | 1 | Bus occupied between START and STOP |
| irq_req | output | 1 | Sticky interrupt request |
| cfg_bad | output | 1 | Threshold is zero or odd |
| gen_timing_sel | output | 1 | Bit 7 of the control byte, passed to the generator |

## Verification
The bench changes SDA on a falling clock edge. It then books the expected pulse and its type in the scoreboard queue, due exactly H+3 cycle counts later. The monitor compares each pulse it sees against the head of the queue, in both type and cycle.

The latencies that are checked are as follows:
- A pin change that raises `irq_req` is checked one cycle before and in the cycle it is due, three counts after the change.
- A control-byte or enable change that raises `irq_req` is checked one count after the change.
- `bus_busy` clearing on disable is checked one count after the change.

All samples are taken on the falling clock edge, away from the edge at which the design updates.

// File: rtl/cd_pkg.sv
package cd_pkg;
    localparam int THR_W  = 5;
    localparam int CTRL_W = THR_W + 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCL_HI,
        ST_HOLD_STA,
        ST_HOLD_STO
    } cd_state_e;

    typedef struct packed {
        logic             gen_sel;
        logic             pin_sel;
        logic             pol_sel;
        logic [THR_W-1:0] thr;
    } cd_ctrl_t;
endpackage

// File: rtl/cd_line_sync.sv
module cd_line_sync #(
    parameter int         N       = 2,
    parameter int         STAGES  = 2,
    parameter logic       RST_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_LVL}};
            else        sh <= {sh[STAGES-2:0], din[g]};
        end
        assign dout[g] = sh[STAGES-1];
    end
endmodule

// File: rtl/cd_cond_fsm.sv
module cd_cond_fsm
    import cd_pkg::*;
#(
    parameter int TW = THR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          run,
    input  logic [TW-2:0] half,
    input  logic          scl,
    input  logic          sda,
    output logic          start_pulse,
    output logic          stop_pulse,
    output logic          bus_busy
);
    localparam logic [TW-1:0] ONE  = TW'(1);
    localparam logic [TW-1:0] ZERO = '0;
    localparam logic [TW-1:0] CMAX = '1;

    cd_state_e     state, state_n;
    logic [TW-1:0] cnt, cnt_n, hcnt, hcnt_n, hnext, half_ext;
    logic          sda_q, sda_edge, sta_hit, sto_hit;

    assign half_ext = {1'b0, half};
    assign sda_edge = sda ^ sda_q;
    assign hnext    = hcnt + ONE;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        hcnt_n  = hcnt;
        sta_hit = 1'b0;
        sto_hit = 1'b0;
        if (!run) begin
            state_n = ST_IDLE;
            cnt_n   = ZERO;
            hcnt_n  = ZERO;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (scl) begin
                        state_n = ST_SCL_HI;
                        cnt_n   = ONE;
                    end
                end
                ST_SCL_HI: begin
                    if (!scl) begin
                        state_n = ST_IDLE;
                        cnt_n   = ZERO;
                    end else if (sda_edge) begin
                        if (cnt >= half_ext) begin
                            state_n = sda ? ST_HOLD_STO : ST_HOLD_STA;
                            hcnt_n  = ZERO;
                        end else begin
                            cnt_n = ZERO;
                        end
                    end else if (cnt != CMAX) begin
                        cnt_n = cnt + ONE;
                    end
                end
                ST_HOLD_STA, ST_HOLD_STO: begin
                    if (!scl) begin
                        state_n = ST_IDLE;
                        cnt_n   = ZERO;
                    end else if (sda_edge) begin
                        state_n = ST_SCL_HI;
                        cnt_n   = ZERO;
                    end else if (hnext == half_ext) begin
                        sta_hit = (state == ST_HOLD_STA);
                        sto_hit = (state == ST_HOLD_STO);
                        state_n = ST_SCL_HI;
                        cnt_n   = hnext;
                    end else begin
                        hcnt_n = hnext;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= ZERO;
            hcnt  <= ZERO;
            sda_q <= 1'b1;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            hcnt  <= hcnt_n;
            sda_q <= sda;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            bus_busy    <= 1'b0;
        end else begin
            start_pulse <= sta_hit;
            stop_pulse  <= sto_hit;
            if (!bus_en)      bus_busy <= 1'b0;
            else if (sta_hit) bus_busy <= 1'b1;
            else if (sto_hit) bus_busy <= 1'b0;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R2
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse); // R3
    AST_HOLD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD_STA || state == ST_HOLD_STO) && !scl |=> !start_pulse && !stop_pulse); // R4
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> bus_busy); // R6
    AST_DIS_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !bus_busy); // R6
endmodule

// File: rtl/cd_pin_irq.sv
module cd_pin_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en,
    input  logic pin_sel,
    input  logic pol_sel,
    input  logic scl,
    input  logic sda,
    input  logic irq_clr,
    output logic irq_req
);
    logic pin, mon, mon_q;

    assign pin = pin_sel ? sda : scl;
    assign mon = bus_en & (pol_sel ? pin : ~pin);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q   <= 1'b0;
            irq_req <= 1'b0;
        end else begin
            mon_q <= mon;
            if (mon && !mon_q) irq_req <= 1'b1;
            else if (irq_clr)  irq_req <= 1'b0;
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_clr |=> irq_req); // R8
    AST_IRQ_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en && !irq_req |=> !irq_req); // R11
endmodule

// File: rtl/cond_detect.sv
module cond_detect
    import cd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              irq_clr,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              bus_busy,
    output logic              irq_req,
    output logic              cfg_bad,
    output logic              gen_timing_sel
);
    cd_ctrl_t   cfg;
    logic       thr_ok, run;
    logic [1:0] raw_lines, s_lines;

    assign cfg            = cd_ctrl_t'(ctrl);
    assign thr_ok         = (cfg.thr != '0) && !cfg.thr[0];
    assign cfg_bad        = !thr_ok;
    assign run            = bus_en && thr_ok;
    assign gen_timing_sel = cfg.gen_sel;
    assign raw_lines      = {sda_in, scl_in};

    cd_line_sync #(.N(2), .STAGES(2), .RST_LVL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (s_lines)
    );

    cd_cond_fsm #(.TW(THR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .run        (run),
        .half       (cfg.thr[THR_W-1:1]),
        .scl        (s_lines[0]),
        .sda        (s_lines[1]),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .bus_busy   (bus_busy)
    );

    cd_pin_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_en (bus_en),
        .pin_sel(cfg.pin_sel),
        .pol_sel(cfg.pol_sel),
        .scl    (s_lines[0]),
        .sda    (s_lines[1]),
        .irq_clr(irq_clr),
        .irq_req(irq_req)
    );

    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad && $past(cfg_bad) |-> !start_pulse && !stop_pulse); // R5
endmodule

// File: tb/cond_detect_test.sv
module cond_detect_test;
    logic       clk = 1'b0, rst_n = 1'b0, bus_en = 1'b1;
    logic       scl = 1'b1, sda = 1'b1, irq_clr = 1'b0;
    logic [7:0] ctrl = 8'h08;
    logic       start_pulse, stop_pulse, bus_busy, irq_req, cfg_bad, gen_timing_sel;

    cond_detect uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .scl_in(scl), .sda_in(sda),
        .ctrl(ctrl), .irq_clr(irq_clr), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .bus_busy(bus_busy), .irq_req(irq_req),
        .cfg_bad(cfg_bad), .gen_timing_sel(gen_timing_sel)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { bit is_stop; int due; } exp_t;
    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
    endtask

    // driver: build one condition, book the expected pulse in the scoreboard
    task automatic cond(bit is_stop, int s, int h, bit expect_it);
        scl = 1'b0;
        step(3);
        sda = is_stop ? 1'b0 : 1'b1;
        step(3);
        scl = 1'b1;
        step(s);
        sda = ~sda;
        if (expect_it) q.push_back('{is_stop, cyc + 3 + int'(ctrl[4:1])});
        step(1 + h);
        scl = 1'b0;
        step(2);
    endtask

    // monitor: compare each pulse with the head of the queue
    always @(negedge clk) begin
        if (rst_n && (start_pulse || stop_pulse)) begin
            if (start_pulse && stop_pulse) begin
                chk(1'b0, "R3", "both pulses at once", 1, 0);
            end else if (q.size() == 0) begin
                chk(1'b0, "R4", "unexpected pulse at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.is_stop == stop_pulse, e.is_stop ? "R3" : "R2",
                    "pulse type (1=stop)", int'(stop_pulse), int'(e.is_stop));
                chk(e.due == cyc, e.is_stop ? "R3" : "R2", "pulse cycle", cyc, e.due);
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_up();
        end
    end

    initial begin
        int c;
        step(4);
        chk(start_pulse == 1'b0, "R1", "start_pulse in reset", int'(start_pulse), 0);
        chk(stop_pulse == 1'b0, "R1", "stop_pulse in reset", int'(stop_pulse), 0);
        chk(bus_busy == 1'b0, "R1", "bus_busy in reset", int'(bus_busy), 0);
        chk(irq_req == 1'b0, "R1", "irq_req in reset", int'(irq_req), 0);
        rst_n = 1'b1;
        step(4);
        chk(cfg_bad == 1'b0, "R5", "cfg_bad for T=8", int'(cfg_bad), 0);

        // nominal START and STOP with T=8 (H=4), exact boundary
        cond(1'b0, 4, 4, 1'b1);
        chk(bus_busy == 1'b1, "R6", "busy after START", int'(bus_busy), 1);
        cond(1'b1, 4, 4, 1'b1);
        chk(bus_busy == 1'b0, "R6", "busy after STOP", int'(bus_busy), 0);

        // short setup and short hold are rejected
        cond(1'b0, 3, 6, 1'b0);
        chk(bus_busy == 1'b0, "R4", "busy after short setup", int'(bus_busy), 0);
        cond(1'b0, 6, 3, 1'b0);
        chk(bus_busy == 1'b0, "R4", "busy after short hold", int'(bus_busy), 0);

        // illegal thresholds
        ctrl = 8'h07;
        step(1);
        chk(cfg_bad == 1'b1, "R5", "cfg_bad for T=7", int'(cfg_bad), 1);
        cond(1'b0, 8, 8, 1'b0);
        chk(bus_busy == 1'b0, "R5", "busy with odd T", int'(bus_busy), 0);
        ctrl = 8'h00;
        step(1);
        chk(cfg_bad == 1'b1, "R5", "cfg_bad for T=0", int'(cfg_bad), 1);

        // bit 7 set: detection unchanged, bit passed through
        ctrl = 8'h88;
        step(1);
        chk(gen_timing_sel == 1'b1, "R10", "gen_timing_sel", int'(gen_timing_sel), 1);
        cond(1'b0, 4, 4, 1'b1);
        chk(bus_busy == 1'b1, "R10", "busy after START with bit7", int'(bus_busy), 1);

        // disabling clears busy and blocks detection
        bus_en = 1'b0;
        c = cyc;
        wait_to(c + 1);
        chk(bus_busy == 1'b0, "R6", "busy after disable", int'(bus_busy), 0);
        cond(1'b1, 8, 8, 1'b0);
        chk(stop_pulse == 1'b0, "R11", "stop while disabled", int'(stop_pulse), 0);
        bus_en = 1'b1;
        step(3);

        // smallest and largest legal thresholds
        ctrl = 8'h02;
        cond(1'b0, 1, 1, 1'b1);
        cond(1'b1, 1, 1, 1'b1);
        ctrl = 8'h1E;
        cond(1'b0, 15, 15, 1'b1);
        cond(1'b1, 15, 15, 1'b1);
        ctrl = 8'h08;
        step(4);

        // interrupts: SDA, falling
        sda = 1'b1;
        step(4);
        ctrl = 8'h48;
        step(4);
        clr_irq();
        chk(irq_req == 1'b0, "R8", "irq after clear", int'(irq_req), 0);
        sda = 1'b0;
        c = cyc;
        wait_to(c + 2);
        chk(irq_req == 1'b0, "R7", "irq one cycle early", int'(irq_req), 0);
        wait_to(c + 3);
        chk(irq_req == 1'b1, "R7", "irq on SDA fall", int'(irq_req), 1);
        step(10);
        chk(irq_req == 1'b1, "R8", "irq held", int'(irq_req), 1);
        clr_irq();
        chk(irq_req == 1'b0, "R8", "irq cleared", int'(irq_req), 0);
        sda = 1'b1;
        step(6);
        chk(irq_req == 1'b0, "R7", "SDA rise with falling selected", int'(irq_req), 0);

        // polarity change raises a request
        ctrl = 8'h68;
        c = cyc;
        wait_to(c + 1);
        chk(irq_req == 1'b1, "R9", "irq on polarity change", int'(irq_req), 1);
        clr_irq();
        sda = 1'b0;
        step(6);
        chk(irq_req == 1'b0, "R7", "SDA fall with rising selected", int'(irq_req), 0);
        sda = 1'b1;
        c = cyc;
        wait_to(c + 3);
        chk(irq_req == 1'b1, "R7", "irq on SDA rise", int'(irq_req), 1);

        // SCL, rising
        clr_irq();
        ctrl = 8'h28;
        step(3);
        chk(irq_req == 1'b0, "R7", "no irq selecting low SCL", int'(irq_req), 0);
        scl = 1'b1;
        c = cyc;
        wait_to(c + 3);
        chk(irq_req == 1'b1, "R7", "irq on SCL rise", int'(irq_req), 1);

        // disabled: no requests; enabling raises one
        bus_en = 1'b0;
        step(3);
        clr_irq();
        scl = 1'b0;
        step(4);
        scl = 1'b1;
        step(4);
        chk(irq_req == 1'b0, "R11", "irq while disabled", int'(irq_req), 0);
        bus_en = 1'b1;
        c = cyc;
        wait_to(c + 1);
        chk(irq_req == 1'b1, "R9", "irq on enable", int'(irq_req), 1);

        step(10);
        chk(q.size() == 0, "R2", "pulses still pending", q.size(), 0);
        done = 1'b1;
        finish_up();
    end
endmodule